// File: doc/BRIEF.md
# Mixed Access-Policy Register Bank

This block is a small register file on a plain address/data bus. It has two registers. The control register at offset 0x0 holds a clock-source select and a 4-bit divide value N. Both fields are driven out to a clock divider that sits outside this block. That divider produces a beat rate of the source clock divided by N+1. The policy register at offset 0x4 gives each bit from 31 down to 4 its own access rule. The rules cover read-only, plain read-write, changes caused by a read, changes caused by a write, changes that depend on the data value written, write-only bits and bits that can be written once.

A read returns its data combinationally in the same cycle as `bus_re`. The returned value is the one held before the access. All read and write side effects land on the next rising clock edge. Bit 31 shows a hardware status input directly. Bit 4 is a sticky event bit: a hardware pulse sets it and a read clears it. The bits that software cannot read are driven out on `wo_bits` so the logic that uses them can see them.

Top module: `mixed_policy_regs`

## Requirements
- R1: After reset, offset 0x0 reads 0x8000, with `clk_src_sel`=1 (internal oscillator) and `div_value`=0. Bits 30..4 of offset 0x4 read 0.
- R2: A write to offset 0x0 stores data bit 15 into `clk_src_sel` and data bits 3..0 into `div_value`. Offset 0x0 bits 14..4 always read 0 and ignore writes.
- R3: `bus_rdata` is 0 whenever `bus_re` is low. While `bus_re` is high, `bus_rdata` shows in the same cycle the value held before the access. Any side effect of that access appears from the next clock edge.
- R4: Offset 0x4 bit 31 reads the level of `hw_status_in` and ignores writes. Offset 0x4 bits 3..0 read 0 and ignore writes.
- R5: Bits 30 and 5 are plain read-write. Bits 27 and 26 take the written data bit.
- R6: A read of offset 0x4 clears bits 29, 27, 23, 15 and 13. The same read sets bits 28, 26, 22, 14 and 12. Bits 29 and 28 ignore writes.
- R7: Any write to offset 0x4 clears bits 25, 22 and 10, and sets bits 24, 23 and 8, whatever the data.
- R8: A written 1 clears bit 21, sets bit 20 and toggles bit 19; a written 1 also sets bit 15 and clears bit 14. A written 0 clears bit 18, sets bit 17 and toggles bit 16; a written 0 also sets bit 13 and clears bit 12. The opposite data value leaves each of these bits unchanged.
- R9: Bits 11, 10, 9, 8 and 6 always read 0. Their held values appear on `wo_bits` as {bit11, bit10, bit9, bit8, bit6}. Bits 11 and 9 take the written data bit.
- R10: Bits 7 and 6 each take the data of the first write to offset 0x4 after reset. Every later write leaves them unchanged until the next reset. Bit 7 is readable.
- R11: When a read and a write of offset 0x4 happen in the same cycle, the write effect is applied first. The read side effect then overrides it on every bit that has both kinds of effect.
- R12: A pulse on `hw_event_in` sets bit 4. A read of offset 0x4 clears bit 4. If both happen in the same cycle, the bit ends set. Writes do not change bit 4.
- R13: Reads and writes to any other address return 0 and change nothing. Reads of offset 0x0 have no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_re` |
| hw_status_in | input | 1 | Level shown on offset 0x4 bit 31 |
| hw_event_in | input | 1 | Pulse that sets offset 0x4 bit 4 |
| clk_src_sel | output | 1 | 1 = internal oscillator, 0 = bus clock |
| div_value | output | 4 | Divide value N |
| wo_bits | output | 5 | Held values of bits {11,10,9,8,6} |

## Verification
A read side effect and a write effect can hit the same register in one clock. Bit 4 adds a second overlap, because a hardware event can arrive in the same clock as the read that clears it. Both overlaps are provoked on purpose:
- a read and a write to offset 0x4 are driven together with all-ones and all-zeros data;
- `hw_event_in` is pulsed during a read;
- a long stretch of mixed random traffic follows.

After every edge, the result is judged by reading the register back and by watching `wo_bits`. Each value is compared with a bench model that applies the write effect first, then the read override, then the event.

// File: rtl/mixed_policy_regs.sv
module mixed_policy_regs #(
  parameter int ADDR_W = 4,
  parameter int CTRL_OFS = 0,
  parameter int POL_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic              hw_status_in,
  input  logic              hw_event_in,
  output logic              clk_src_sel,
  output logic [3:0]        div_value,
  output logic [4:0]        wo_bits
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(POL_OFS);

  logic        hit_ctrl, hit_pol, wr_pol, rd_pol;
  logic [30:4] r, nx;
  logic        once7, once6;
  logic [31:0] rd_ctrl, rd_pol_v;
  logic [31:0] d;

  assign d        = bus_wdata;
  assign hit_ctrl = bus_addr == A_CTRL;
  assign hit_pol  = bus_addr == A_POL;
  assign wr_pol   = bus_we & hit_pol;
  assign rd_pol   = bus_re & hit_pol;

  always_comb begin
    nx = r;
    if (wr_pol) begin
      nx[30] = d[30];
      nx[27] = d[27];
      nx[26] = d[26];
      nx[25] = 1'b0;
      nx[24] = 1'b1;
      nx[23] = 1'b1;
      nx[22] = 1'b0;
      if (d[21])  nx[21] = 1'b0;
      if (d[20])  nx[20] = 1'b1;
      if (d[19])  nx[19] = ~r[19];
      if (!d[18]) nx[18] = 1'b0;
      if (!d[17]) nx[17] = 1'b1;
      if (!d[16]) nx[16] = ~r[16];
      if (d[15])  nx[15] = 1'b1;
      if (d[14])  nx[14] = 1'b0;
      if (!d[13]) nx[13] = 1'b1;
      if (!d[12]) nx[12] = 1'b0;
      nx[11] = d[11];
      nx[10] = 1'b0;
      nx[9]  = d[9];
      nx[8]  = 1'b1;
      if (!once7) nx[7] = d[7];
      if (!once6) nx[6] = d[6];
      nx[5] = d[5];
    end
    if (rd_pol) begin
      nx[29] = 1'b0;
      nx[28] = 1'b1;
      nx[27] = 1'b0;
      nx[26] = 1'b1;
      nx[23] = 1'b0;
      nx[22] = 1'b1;
      nx[15] = 1'b0;
      nx[14] = 1'b1;
      nx[13] = 1'b0;
      nx[12] = 1'b1;
      nx[4]  = 1'b0;
    end
    if (hw_event_in) nx[4] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r           <= '0;
      once7       <= 1'b0;
      once6       <= 1'b0;
      clk_src_sel <= 1'b1;
      div_value   <= 4'd0;
    end else begin
      r <= nx;
      if (wr_pol) begin
        once7 <= 1'b1;
        once6 <= 1'b1;
      end
      if (bus_we && hit_ctrl) begin
        clk_src_sel <= d[15];
        div_value   <= d[3:0];
      end
    end
  end

  assign rd_ctrl  = {clk_src_sel, 11'd0, div_value};
  assign rd_pol_v = {hw_status_in, r[30:12], 4'd0, r[7], 1'b0, r[5], r[4], 4'd0};
  assign bus_rdata = !bus_re  ? 32'd0 :
                     hit_ctrl ? rd_ctrl :
                     hit_pol  ? rd_pol_v : 32'd0;
  assign wo_bits = {r[11], r[10], r[9], r[8], r[6]};
endmodule

module mixed_policy_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int CTRL_OFS = 0,
  parameter int POL_OFS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic              hw_status_in,
  input logic              hw_event_in,
  input logic [30:4]       r,
  input logic              once7
);
  logic rd4, wr4, rd0;
  assign rd4 = bus_re && bus_addr == ADDR_W'(POL_OFS);
  assign wr4 = bus_we && bus_addr == ADDR_W'(POL_OFS);
  assign rd0 = bus_re && bus_addr == ADDR_W'(CTRL_OFS);

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> bus_rdata == 32'd0);
  a_r4_status_and_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    rd4 |-> (bus_rdata[31] == hw_status_in && bus_rdata[3:0] == 4'd0));
  a_r2_ctrl_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 |-> bus_rdata[14:4] == 11'd0);
  a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd4 |-> (bus_rdata[11:8] == 4'd0 && !bus_rdata[6]));
  a_r6_read_clears_29: assert property (@(posedge clk) disable iff (!rst_n)
    rd4 |=> !r[29]);
  a_r8_w1_toggle_19: assert property (@(posedge clk) disable iff (!rst_n)
    (wr4 && bus_wdata[19]) |=> r[19] != $past(r[19]));
  a_r10_once_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr4 && once7) |=> r[7] == $past(r[7]));
  a_r12_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_event_in |=> r[4]);
endmodule

bind mixed_policy_regs mixed_policy_regs_chk #(
  .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .POL_OFS(POL_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .hw_status_in(hw_status_in), .hw_event_in(hw_event_in),
  .r(r), .once7(once7)
);

// File: tb/sim_mixed_policy_regs.sv
`timescale 1ns/1ps
module sim_mixed_policy_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        hw_status_in = 1'b0;
  logic        hw_event_in = 1'b0;
  logic        clk_src_sel;
  logic [3:0]  div_value;
  logic [4:0]  wo_bits;

  int checks = 0;
  int errors = 0;

  logic [31:0] m;
  logic        f7, f6, m_osc;
  logic [3:0]  m_div;

  always #2 clk = ~clk;

  mixed_policy_regs #(.ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .hw_status_in(hw_status_in), .hw_event_in(hw_event_in),
    .clk_src_sel(clk_src_sel), .div_value(div_value), .wo_bits(wo_bits)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata();
    logic [31:0] v;
    if (!bus_re) return 32'd0;
    if (bus_addr == 4'd0) return {m_osc, 11'd0, m_div};
    if (bus_addr != 4'd4) return 32'd0;
    v = m;
    v[31] = hw_status_in;
    v[11] = 1'b0; v[10] = 1'b0; v[9] = 1'b0; v[8] = 1'b0; v[6] = 1'b0;
    v[3:0] = 4'd0;
    return v;
  endfunction

  task automatic model_reset();
    m = '0; f7 = 1'b0; f6 = 1'b0; m_osc = 1'b1; m_div = 4'd0;
  endtask

  task automatic model_edge();
    logic [31:0] nm;
    logic wr, rd, v, db;
    wr = bus_we && bus_addr == 4'd4;
    rd = bus_re && bus_addr == 4'd4;
    nm = m;
    for (int b = 4; b <= 30; b++) begin
      v = m[b];
      db = bus_wdata[b];
      if (wr) begin
        case (b)
          30, 27, 26, 11, 9, 5: v = db;
          25, 22, 10: v = 1'b0;
          24, 23, 8: v = 1'b1;
          21: if (db) v = 1'b0;
          20: if (db) v = 1'b1;
          19: if (db) v = !v;
          18: if (!db) v = 1'b0;
          17: if (!db) v = 1'b1;
          16: if (!db) v = !v;
          15: if (db) v = 1'b1;
          14: if (db) v = 1'b0;
          13: if (!db) v = 1'b1;
          12: if (!db) v = 1'b0;
          7: if (!f7) v = db;
          6: if (!f6) v = db;
          default: ;
        endcase
      end
      if (rd) begin
        case (b)
          29, 27, 23, 15, 13, 4: v = 1'b0;
          28, 26, 22, 14, 12: v = 1'b1;
          default: ;
        endcase
      end
      if (b == 4 && hw_event_in) v = 1'b1;
      nm[b] = v;
    end
    if (wr) begin f7 = 1'b1; f6 = 1'b1; end
    if (bus_we && bus_addr == 4'd0) begin
      m_osc = bus_wdata[15];
      m_div = bus_wdata[3:0];
    end
    m = nm;
  endtask

  task automatic cyc(input string tag, input logic [3:0] a, input logic we,
                     input logic [31:0] d, input logic re,
                     input logic hs, input logic ev);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d; bus_re = re;
    hw_status_in = hs; hw_event_in = ev;
    #1;
    check({tag, " rdata"}, bus_rdata, exp_rdata());
    check({tag, " ctrl"}, {27'd0, clk_src_sel, div_value}, {27'd0, m_osc, m_div});
    check({tag, " wo_bits"}, {27'd0, wo_bits}, {27'd0, m[11], m[10], m[9], m[8], m[6]});
    @(posedge clk);
    model_edge();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; hw_event_in = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R1 reset state
    cyc("R1 reset ctrl", 4'd0, 0, 0, 1, 0, 0);
    cyc("R1 reset pol", 4'd4, 0, 0, 1, 1, 0);
    // R2 control register
    cyc("R2 write ctrl", 4'd0, 1, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R2 read ctrl", 4'd0, 0, 0, 1, 0, 0);
    cyc("R2 write ctrl2", 4'd0, 1, 32'h0000_7FF5, 0, 0, 0);
    cyc("R2 read ctrl2", 4'd0, 0, 0, 1, 0, 0);
    // R13 unmapped and side-effect-free reads
    cyc("R13 unmapped write", 4'd8, 1, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R13 unmapped read", 4'd2, 0, 0, 1, 1, 0);
    cyc("R13 ctrl read no effect", 4'd0, 0, 0, 1, 0, 0);
    cyc("R13 pol check", 4'd4, 0, 0, 1, 0, 0);
    // R10 first write to bit 7 and 6 is all ones
    cyc("R10 first write", 4'd4, 1, 32'hFFFF_FFFF, 0, 1, 0);
    cyc("R10 readback", 4'd4, 0, 0, 1, 1, 0);
    cyc("R10 locked write", 4'd4, 1, 32'h0000_0000, 0, 0, 0);
    cyc("R10 locked read", 4'd4, 0, 0, 1, 0, 0);
    // R5 R7 R8 R9 patterns
    cyc("R8 zeros", 4'd4, 1, 32'h0000_0000, 0, 0, 0);
    cyc("R8 read", 4'd4, 0, 0, 1, 0, 0);
    cyc("R8 ones", 4'd4, 1, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R7 read", 4'd4, 0, 0, 1, 0, 0);
    cyc("R5 pattern", 4'd4, 1, 32'hA5A5_A5A0, 0, 0, 0);
    cyc("R9 read", 4'd4, 0, 0, 1, 0, 0);
    cyc("R5 pattern2", 4'd4, 1, 32'h5A5A_5A50, 0, 0, 0);
    // R6 and R3: back-to-back reads show pre-effect value then effect
    cyc("R6 read1", 4'd4, 0, 0, 1, 0, 0);
    cyc("R3 read2", 4'd4, 0, 0, 1, 0, 0);
    cyc("R3 idle", 4'd4, 0, 0, 0, 0, 0);
    // R11 read and write together
    cyc("R11 rw ones", 4'd4, 1, 32'hFFFF_FFFF, 1, 1, 0);
    cyc("R11 check", 4'd4, 0, 0, 1, 0, 0);
    cyc("R11 rw zeros", 4'd4, 1, 32'h0000_0000, 1, 0, 0);
    cyc("R11 check2", 4'd4, 0, 0, 1, 0, 0);
    // R12 event bit
    cyc("R12 event", 4'd4, 0, 0, 0, 0, 1);
    cyc("R12 write no effect", 4'd4, 1, 32'h0000_0000, 0, 0, 0);
    cyc("R12 read set", 4'd4, 0, 0, 1, 0, 0);
    cyc("R12 read cleared", 4'd4, 0, 0, 1, 0, 0);
    cyc("R12 event during read", 4'd4, 0, 0, 1, 0, 1);
    cyc("R12 still set", 4'd4, 0, 0, 1, 0, 0);
    // R4 status input tracks
    cyc("R4 status high", 4'd4, 1, 32'h0000_000F, 1, 1, 0);
    cyc("R4 status low", 4'd4, 0, 0, 1, 0, 0);
    // R10 after fresh reset: first write zeros
    do_reset();
    cyc("R1 after reset", 4'd4, 0, 0, 1, 0, 0);
    cyc("R10 first zeros", 4'd4, 1, 32'h0000_0000, 0, 0, 0);
    cyc("R10 ones ignored", 4'd4, 1, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R10 read", 4'd4, 0, 0, 1, 0, 0);
    // mixed random traffic, covers R3 R6 R7 R8 R11 R12
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic [31:0] rv;
      rv = $urandom;
      a = rv[1] ? 4'd4 : (rv[0] ? 4'd0 : 4'(rv[5:2]));
      cyc("R11 mix", a, rv[6], $urandom, rv[7], rv[8], rv[9] & rv[10]);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule